// File: doc/BRIEF.md
# External Bus Word Packer

This block converts one internal word access into the sequence of narrow cycles that an external memory bus needs. An internal requester presents an address, a word size (16 or 24 bits), a direction and, for writes, the word. The external bus has a 20-bit address and a data path that is either 8 or 16 bits wide, chosen by a mode input. A single access therefore becomes one, two or three external cycles.

On a write, the unit splits the word into slices and places one slice on the bus in each cycle. On a read, it collects the slices returned in each cycle into one word. It then reports completion with a one-cycle pulse. Only one requester is served at a time. A busy flag tells the shared request interface when the next access can be offered.

Each external cycle lasts one clock. Wait states and chip-select decoding belong to the surrounding logic.

Top module: `xport_packer`

## Requirements
- R1: After reset, `busy`, `done`, `ext_rd` and `ext_wr` are low, and `ext_dout`, `ext_addr` and `rd_data` are zero.
- R2: A request is accepted at a rising edge where `req_valid` is high and `busy` is low. `busy` is high from the following cycle through the cycle in which `done` is high. Any request presented while `busy` is high is ignored.
- R3: The number of external cycles per access is fixed by the bus width and the word size. With `bus16_mode`=0, a 16-bit word (`req_wide`=0) takes 2 cycles and a 24-bit word (`req_wide`=1) takes 3. With `bus16_mode`=1, a 16-bit word takes 1 cycle and a 24-bit word takes 2. The cycles are the consecutive clock cycles straight after acceptance. In each of them exactly one of `ext_rd` (read, `req_write`=0) or `ext_wr` (write, `req_write`=1) is high.
- R4: In external cycle k (counting from 0), `ext_addr` equals the accepted address plus k, modulo 2^20, so 0xFFFFF is followed by 0x00000.
- R5: On the 8-bit bus, write cycle k drives word bits [8k+7:8k] on `ext_dout[7:0]`, and `ext_dout[15:8]` is zero.
- R6: On the 16-bit bus, write cycle 0 drives word bits [15:0] on `ext_dout[15:0]`. For a 24-bit word, cycle 1 drives bits [23:16] on `ext_dout[7:0]`, with `ext_dout[15:8]` zero.
- R7: On the 8-bit bus, `ext_din[7:0]` is sampled at the rising edge that ends read cycle k and becomes word bits [8k+7:8k]. `ext_din[15:8]` is ignored.
- R8: On the 16-bit bus, `ext_din` sampled at the end of read cycle 0 becomes word bits [15:0]. For a 24-bit word, `ext_din[7:0]` of cycle 1 becomes bits [23:16]. A 16-bit word read returns bits [23:16] as zero.
- R9: `done` is a single-cycle pulse in the cycle after the last external cycle, for reads and writes alike. While it is high, no strobe is active and `rd_data` holds the assembled word. `rd_data` keeps that value until the next request is accepted.
- R10: Address, data, direction, word size and `bus16_mode` are captured at acceptance. Changing any of them while `busy` is high has no effect on the access in progress.
- R11: Outside write cycles, `ext_dout` is zero. Outside any external cycle, `ext_addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus16_mode | input | 1 | 1 selects the 16-bit external data path, 0 the 8-bit one |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 write, 0 read |
| req_wide | input | 1 | 1 for a 24-bit word, 0 for a 16-bit word |
| req_addr | input | 20 | External base address |
| req_wdata | input | 24 | Write word (bits [15:0] used for 16-bit words) |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 24 | Assembled read word |
| ext_addr | output | 20 | External address |
| ext_rd | output | 1 | External read strobe |
| ext_wr | output | 1 | External write strobe |
| ext_dout | output | 16 | External write data |
| ext_din | input | 16 | External read data |

## Verification
Two events can land in the same cycle: the completion of an access (the `done` cycle) and the arrival of a fresh request from the shared interface. The bench provokes this by keeping `req_valid` high throughout a transfer, with a different address, direction, size and bus mode. It then checks that the `done` cycle is followed by a cycle with no strobe, that the access in progress keeps its captured parameters, and that only a request still present in the idle cycle would start a new access. Read data on the unused upper lanes is made non-zero, so that any leak into the assembled word shows up.

// File: rtl/xport_pkg.sv
package xport_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BEAT = 2'd1,
    ST_DONE = 2'd2
  } xp_state_t;

  // index of the final external cycle for a given bus width and word size
  function automatic logic [1:0] last_beat_of(input logic b16, input logic wide);
    logic [1:0] r;
    if (b16) r = wide ? 2'd1 : 2'd0;
    else     r = wide ? 2'd2 : 2'd1;
    return r;
  endfunction

endpackage

// File: rtl/xport_reg.sv
module xport_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (en) q_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

endmodule

// File: rtl/xport_seq.sv
module xport_seq
  import xport_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BEAT_W-1:0] last_in,
  output logic              busy,
  output logic              active,
  output logic              done,
  output logic [BEAT_W-1:0] beat
);

  xp_state_t         state_q, state_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [BEAT_W-1:0] last_q, last_d;

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    last_d  = last_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_BEAT;
          beat_d  = '0;
          last_d  = last_in;
        end
      end
      ST_BEAT: begin
        if (beat_q == last_q) state_d = ST_DONE;
        else                  beat_d  = beat_q + 1'b1;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      last_q  <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      last_q  <= last_d;
    end
  end

  assign busy   = (state_q != ST_IDLE);
  assign active = (state_q == ST_BEAT);
  assign done   = (state_q == ST_DONE);
  assign beat   = beat_q;

endmodule

// File: rtl/xport_lanes.sv
module xport_lanes #(
  parameter int WORD_W = 24,
  parameter int BUS_W  = 16,
  parameter int BEAT_W = 2
) (
  input  logic              b16,
  input  logic [BEAT_W-1:0] beat,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] acc,
  input  logic [BUS_W-1:0]  din,
  output logic [BUS_W-1:0]  dout,
  output logic [WORD_W-1:0] acc_next
);

  localparam int LANE_W = BUS_W / 2;
  localparam int HI_W   = WORD_W - BUS_W;

  // write slice selection
  always_comb begin
    dout = '0;
    if (!b16) begin
      unique case (beat)
        2'd0:    dout[LANE_W-1:0] = wdata[LANE_W-1:0];
        2'd1:    dout[LANE_W-1:0] = wdata[2*LANE_W-1:LANE_W];
        default: dout[LANE_W-1:0] = wdata[3*LANE_W-1:2*LANE_W];
      endcase
    end else if (beat == '0) begin
      dout = wdata[BUS_W-1:0];
    end else begin
      dout[HI_W-1:0] = wdata[WORD_W-1:BUS_W];
    end
  end

  // read slice merge
  always_comb begin
    acc_next = acc;
    if (!b16) begin
      unique case (beat)
        2'd0:    acc_next[LANE_W-1:0]          = din[LANE_W-1:0];
        2'd1:    acc_next[2*LANE_W-1:LANE_W]   = din[LANE_W-1:0];
        default: acc_next[3*LANE_W-1:2*LANE_W] = din[LANE_W-1:0];
      endcase
    end else if (beat == '0) begin
      acc_next[BUS_W-1:0] = din;
    end else begin
      acc_next[WORD_W-1:BUS_W] = din[HI_W-1:0];
    end
  end

endmodule

// File: rtl/xport_packer.sv
module xport_packer
  import xport_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int WORD_W = 24,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus16_mode,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rd_data,
  output logic [ADDR_W-1:0] ext_addr,
  output logic              ext_rd,
  output logic              ext_wr,
  output logic [BUS_W-1:0]  ext_dout,
  input  logic [BUS_W-1:0]  ext_din
);

  localparam int BEAT_W = 2;
  localparam int CAP_W  = ADDR_W + WORD_W + 3;

  logic              accept;
  logic              active;
  logic [BEAT_W-1:0] beat;
  logic [CAP_W-1:0]  cap_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q;
  logic              wr_q, b16_q;
  logic [BUS_W-1:0]  lane_dout;
  logic [WORD_W-1:0] acc_q, acc_next, acc_d;
  logic              acc_en;

  assign accept = req_valid && !busy;

  // request capture
  xport_reg #(.W(CAP_W)) u_cap (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (accept),
    .d     ({req_addr, req_wdata, req_write, req_wide, bus16_mode}),
    .q     (cap_q)
  );

  assign addr_q  = cap_q[CAP_W-1 -: ADDR_W];
  assign wdata_q = cap_q[WORD_W+2:3];
  assign wr_q    = cap_q[2];
  assign b16_q   = cap_q[0];

  xport_seq #(.BEAT_W(BEAT_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .last_in (last_beat_of(bus16_mode, req_wide)),
    .busy    (busy),
    .active  (active),
    .done    (done),
    .beat    (beat)
  );

  xport_lanes #(.WORD_W(WORD_W), .BUS_W(BUS_W), .BEAT_W(BEAT_W)) u_lanes (
    .b16      (b16_q),
    .beat     (beat),
    .wdata    (wdata_q),
    .acc      (acc_q),
    .din      (ext_din),
    .dout     (lane_dout),
    .acc_next (acc_next)
  );

  // read accumulator: cleared at acceptance, merged on each read cycle
  assign acc_en = accept || (active && !wr_q);
  assign acc_d  = accept ? '0 : acc_next;

  xport_reg #(.W(WORD_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (acc_en),
    .d     (acc_d),
    .q     (acc_q)
  );

  assign rd_data  = acc_q;
  assign ext_rd   = active && !wr_q;
  assign ext_wr   = active && wr_q;
  assign ext_addr = active ? addr_q + ADDR_W'(beat) : '0;
  assign ext_dout = ext_wr ? lane_dout : '0;

endmodule

// File: rtl/xport_packer_chk.sv
module xport_packer_chk #(
  parameter int ADDR_W = 20,
  parameter int BUS_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              busy,
  input logic              done,
  input logic              ext_rd,
  input logic              ext_wr,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [BUS_W-1:0]  ext_dout
);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ext_rd && ext_wr)); // R3

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy && !ext_rd && !ext_wr)); // R9

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ((ext_rd || ext_wr) && $past(ext_rd || ext_wr)) |-> (ext_addr == $past(ext_addr) + 1'b1)); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ext_rd && !ext_wr && ext_dout == '0 && ext_addr == '0)); // R11

endmodule

bind xport_packer xport_packer_chk #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .busy      (busy),
  .done      (done),
  .ext_rd    (ext_rd),
  .ext_wr    (ext_wr),
  .ext_addr  (ext_addr),
  .ext_dout  (ext_dout)
);

// File: tb/xport_packer_test.sv
module xport_packer_test;

  logic        clk;
  logic        rst_n;
  logic        bus16_mode;
  logic        req_valid, req_write, req_wide;
  logic [19:0] req_addr;
  logic [23:0] req_wdata;
  logic        busy, done;
  logic [23:0] rd_data;
  logic [19:0] ext_addr;
  logic        ext_rd, ext_wr;
  logic [15:0] ext_dout, ext_din;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  xport_packer uut (
    .clk(clk), .rst_n(rst_n), .bus16_mode(bus16_mode),
    .req_valid(req_valid), .req_write(req_write), .req_wide(req_wide),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rd_data(rd_data),
    .ext_addr(ext_addr), .ext_rd(ext_rd), .ext_wr(ext_wr),
    .ext_dout(ext_dout), .ext_din(ext_din)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // external memory model: upper byte is deliberately non-zero
  function automatic logic [15:0] mem_word(input logic [19:0] a);
    return {a[7:0] ^ 8'h5A, a[7:0] + 8'h33};
  endfunction

  task automatic run(input string tag, input logic wr, input logic wide, input logic b16,
                     input logic [19:0] a, input logic [23:0] wd, input bit disturb);
    int n;
    logic [23:0] exp_rd;
    logic [19:0] ea;
    logic [15:0] ed;
    n = b16 ? (wide ? 2 : 1) : (wide ? 3 : 2);
    exp_rd = '0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_wide = wide; req_addr = a;
    req_wdata = wd; bus16_mode = b16;
    @(negedge clk);
    if (disturb) begin
      req_valid = 1'b1; req_write = ~wr; req_wide = ~wide; req_addr = ~a;
      req_wdata = ~wd; bus16_mode = ~b16;
    end else begin
      req_valid = 1'b0;
    end
    for (int k = 0; k < n; k++) begin
      ea = a + 20'(k);
      chk("R2", {tag, " busy in cycle"}, 32'(busy), 32'd1);
      chk("R4", {tag, " address"}, 32'(ext_addr), 32'(ea));
      chk("R3", {tag, " strobes"}, {30'd0, ext_rd, ext_wr}, {30'd0, ~wr, wr});
      if (disturb) chk("R10", {tag, " strobes kept"}, {31'd0, ext_wr}, {31'd0, wr});
      if (wr) begin
        if (!b16)        ed = {8'h00, wd[8*k +: 8]};
        else if (k == 0) ed = wd[15:0];
        else             ed = {8'h00, wd[23:16]};
        chk(b16 ? "R6" : "R5", {tag, " write lanes"}, 32'(ext_dout), 32'(ed));
      end else begin
        chk("R11", {tag, " dout quiet on read"}, 32'(ext_dout), 32'd0);
        ext_din = mem_word(ea);
        if (!b16)        exp_rd[8*k +: 8] = ext_din[7:0];
        else if (k == 0) exp_rd[15:0] = ext_din;
        else             exp_rd[23:16] = ext_din[7:0];
      end
      @(negedge clk);
    end
    ext_din = 16'hFFFF;
    chk("R9", {tag, " done pulse"}, 32'(done), 32'd1);
    chk("R2", {tag, " busy with done"}, 32'(busy), 32'd1);
    chk("R3", {tag, " strobes end after beats"}, {30'd0, ext_rd, ext_wr}, 32'd0);
    if (!wr) chk(b16 ? "R8" : "R7", {tag, " read word"}, 32'(rd_data), 32'(exp_rd));
    @(negedge clk);
    chk("R9", {tag, " done single"}, 32'(done), 32'd0);
    chk("R2", {tag, " idle after done"}, 32'(busy), 32'd0);
    chk("R2", {tag, " done-cycle request ignored"}, {30'd0, ext_rd, ext_wr}, 32'd0);
    chk("R11", {tag, " idle outputs"}, {ext_addr, ext_dout[11:0]}, 32'd0);
    if (!wr) chk("R9", {tag, " read word held"}, 32'(rd_data), 32'(exp_rd));
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "busy", 32'(busy), 32'd0);
    chk("R1", "done", 32'(done), 32'd0);
    chk("R1", "strobes", {30'd0, ext_rd, ext_wr}, 32'd0);
    chk("R1", "dout/addr", {ext_dout, ext_addr[15:0]}, 32'd0);
    chk("R1", "rd_data", 32'(rd_data), 32'd0);
  endtask

  task automatic t_writes;
    run("w8x16",  1'b1, 1'b0, 1'b0, 20'h01230, 24'hA1B2C3, 1'b0);
    run("w8x24",  1'b1, 1'b1, 1'b0, 20'h04560, 24'h123456, 1'b0);
    run("w16x16", 1'b1, 1'b0, 1'b1, 20'h07890, 24'h9ABCDE, 1'b0);
    run("w16x24", 1'b1, 1'b1, 1'b1, 20'h0ABC0, 24'hFEDCBA, 1'b0);
  endtask

  task automatic t_reads;
    run("r8x16",  1'b0, 1'b0, 1'b0, 20'h00010, 24'h0, 1'b0);
    run("r8x24",  1'b0, 1'b1, 1'b0, 20'h00020, 24'h0, 1'b0);
    run("r16x16", 1'b0, 1'b0, 1'b1, 20'h00030, 24'h0, 1'b0);
    run("r16x24", 1'b0, 1'b1, 1'b1, 20'h00040, 24'h0, 1'b0);
  endtask

  task automatic t_wrap;
    run("wrap_r8x24",  1'b0, 1'b1, 1'b0, 20'hFFFFF, 24'h0, 1'b0);
    run("wrap_w16x24", 1'b1, 1'b1, 1'b1, 20'hFFFFF, 24'h0F1E2D, 1'b0);
  endtask

  task automatic t_disturb;
    run("dist_w8x24",  1'b1, 1'b1, 1'b0, 20'h12340, 24'h5A6B7C, 1'b1);
    run("dist_r16x16", 1'b0, 1'b0, 1'b1, 20'h00050, 24'h0, 1'b1);
    run("dist_r8x24",  1'b0, 1'b1, 1'b0, 20'h00060, 24'h0, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; bus16_mode = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_wide = 1'b0; req_addr = '0; req_wdata = '0; ext_din = 16'hFFFF;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_writes;
    t_reads;
    t_wrap;
    t_disturb;
    repeat (2) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule